// File: doc/BRIEF.md
# DMA Request Accumulator and Arbiter

This block sits between four external DMA request pins and the bus interface of a four-channel memory DMA engine. Each pin belongs to one channel. The pin is asynchronous and edge-sensitive. The block synchronises it, turns each rising edge into one pending request, and holds up to fifteen of them per channel. When a channel is initialised and set to handshake mode, the block starts one bus transaction for each request it holds. When the bus reports that a transaction has completed, the count for that channel drops by one.

A channel in autonomous mode ignores its pin. It asks for transactions back to back until a loaded block length has been used up. The channels share one transaction slot, and a rotating priority decides which channel gets it. Channel 0 can also run transfers between an external device and external memory. In that case the block raises a flyby strobe and holds the internal data enable low for the whole transaction.

Top module: `dreq_arbiter`

## Requirements
- R1: Each request pin passes through a two-flop synchroniser. Each rising edge counts as exactly one request, however long the pin stays high.
- R2: In handshake mode (chanAuto bit 0) on an initialised channel (chanInit bit 1), each accepted request produces exactly one completed transaction on that channel's number.
- R3: An edge is ignored when the channel is not initialised or is in autonomous mode. Clearing a channel's chanInit bit empties its pending count and its remaining block length. A transaction already in flight still completes.
- R4: The pending count saturates at 15. An edge that arrives at 15 is dropped and sets bit i of ovfFlag, which stays set until reset.
- R5: Only one transaction is outstanding at a time. Once txnValid rises, it and txnChan hold until txnDone is sampled high. txnValid is low for at least the cycle after that.
- R6: Grants rotate. The search starts at the channel after the last one granted (channel 0 first after reset), so channels that keep requests pending are served in strictly increasing order, modulo 4.
- R7: While a transaction runs on channel 0 with flybyEn high, flybyOut is high and dataEn is low. Every other transaction drives dataEn high and flybyOut low.
- R8: A one-cycle pulse on bit i of blkLoad loads blkLen as the remaining length of channel i. An initialised channel in autonomous mode then issues exactly that many transactions.
- R9: When an edge is accepted in the same cycle that a transaction completes on that channel, the pending count stays the same, and neither the request nor the completion is lost.
- R10: After reset, txnValid, dataEn and flybyOut are low and ovfFlag is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | 4 | Asynchronous request pins, one per channel |
| chanInit | input | 4 | Channel initialised bits |
| chanAuto | input | 4 | 1 = autonomous mode, 0 = handshake mode |
| flybyEn | input | 1 | Flyby mode for channel 0 |
| blkLoad | input | 4 | Load strobe for a channel's block length |
| blkLen | input | 16 | Block length loaded by blkLoad |
| txnDone | input | 1 | Bus reports that the current transaction has completed |
| txnValid | output | 1 | Transaction request to the bus |
| txnChan | output | 2 | Channel number of the current transaction |
| dataEn | output | 1 | Internal data path takes part in the transaction |
| flybyOut | output | 1 | Flyby strobe for channel 0 |
| ovfFlag | output | 4 | Sticky pending-count overflow flags |

## Verification
An accepted edge and a completed transaction can fall in the same cycle on the same channel. When that happens, the pending counter must hold its value rather than step up or down. The bench provokes this with random pulse trains, random pulse widths and a bus responder that answers after a random delay, so that edges land on completion cycles many times. It judges the result at the ports: after the traffic drains, the number of completed transactions per channel must equal the number of pulses the bench sent to that channel. Directed cases cover saturation, with the bus stalled so that the counter fills, and a channel cleared while a transaction is in flight.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  localparam int NCH = 4;
  localparam int CHW = $clog2(NCH);

  // strobes from control to datapath
  typedef struct packed {
    logic           doneValid;
    logic [CHW-1:0] doneChan;
  } ctrlStrobe_t;
endpackage

// File: rtl/dreq_datapath.sv
module dreq_datapath
  import dreq_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int BLK_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NCH-1:0]   reqIn,
  input  logic [NCH-1:0]   chanInit,
  input  logic [NCH-1:0]   chanAuto,
  input  logic [NCH-1:0]   blkLoad,
  input  logic [BLK_W-1:0] blkLen,
  input  ctrlStrobe_t      strobe,
  output logic [NCH-1:0]   eligible,
  output logic [NCH-1:0]   ovfFlag
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    logic [2:0]       syncQ;
    logic             reqEdge;
    logic             consume;
    logic             accept;
    logic [CNT_W-1:0] pendCnt;
    logic [BLK_W-1:0] blkRemain;
    logic             ovfQ;

    always_ff @(posedge clk) begin
      if (!rstN) syncQ <= '0;
      else       syncQ <= {syncQ[1:0], reqIn[gi]};
    end

    assign reqEdge = syncQ[1] & ~syncQ[2];
    assign consume = strobe.doneValid && (strobe.doneChan == CHW'(gi));
    assign accept  = reqEdge && chanInit[gi] && !chanAuto[gi];

    // pending request counter, handshake mode
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendCnt <= '0;
        ovfQ    <= 1'b0;
      end else if (!chanInit[gi]) begin
        pendCnt <= '0;
      end else begin
        unique case ({accept, consume && (pendCnt != '0) && !chanAuto[gi]})
          2'b10: begin
            if (pendCnt == CNT_MAX) ovfQ <= 1'b1;
            else                    pendCnt <= pendCnt + 1'b1;
          end
          2'b01:   pendCnt <= pendCnt - 1'b1;
          default: pendCnt <= pendCnt;
        endcase
      end
    end

    // remaining block length, autonomous mode
    always_ff @(posedge clk) begin
      if (!rstN) begin
        blkRemain <= '0;
      end else if (!chanInit[gi]) begin
        blkRemain <= '0;
      end else if (blkLoad[gi]) begin
        blkRemain <= blkLen;
      end else if (consume && chanAuto[gi] && (blkRemain != '0)) begin
        blkRemain <= blkRemain - 1'b1;
      end
    end

    assign eligible[gi] = chanInit[gi] &&
                          (chanAuto[gi] ? (blkRemain != '0) : (pendCnt != '0));
    assign ovfFlag[gi]  = ovfQ;
  end
endmodule

// File: rtl/dreq_control.sv
module dreq_control
  import dreq_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic [NCH-1:0] eligible,
  input  logic           flybyEn,
  input  logic           txnDone,
  output ctrlStrobe_t    strobe,
  output logic           txnValid,
  output logic [CHW-1:0] txnChan,
  output logic           dataEn,
  output logic           flybyOut
);
  logic           busy;
  logic [CHW-1:0] curChan;
  logic [CHW-1:0] lastChan;
  logic           pickValid;
  logic [CHW-1:0] pickChan;
  logic [CHW-1:0] idx;

  // rotating search starting after the last grant
  always_comb begin
    pickValid = 1'b0;
    pickChan  = lastChan;
    idx       = lastChan;
    for (int k = 1; k <= NCH; k++) begin
      idx = CHW'((int'(lastChan) + k) % NCH);
      if (!pickValid && eligible[idx]) begin
        pickValid = 1'b1;
        pickChan  = idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      curChan  <= '0;
      lastChan <= CHW'(NCH - 1);
    end else if (busy) begin
      if (txnDone) busy <= 1'b0;
    end else if (pickValid) begin
      busy     <= 1'b1;
      curChan  <= pickChan;
      lastChan <= pickChan;
    end
  end

  logic flyNow;
  assign flyNow           = flybyEn && (curChan == '0);
  assign strobe.doneValid = busy && txnDone;
  assign strobe.doneChan  = curChan;
  assign txnValid         = busy;
  assign txnChan          = curChan;
  assign flybyOut         = busy && flyNow;
  assign dataEn           = busy && !flyNow;
endmodule

// File: rtl/dreq_arbiter.sv
module dreq_arbiter
  import dreq_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int BLK_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NCH-1:0]   reqIn,
  input  logic [NCH-1:0]   chanInit,
  input  logic [NCH-1:0]   chanAuto,
  input  logic             flybyEn,
  input  logic [NCH-1:0]   blkLoad,
  input  logic [BLK_W-1:0] blkLen,
  input  logic             txnDone,
  output logic             txnValid,
  output logic [CHW-1:0]   txnChan,
  output logic             dataEn,
  output logic             flybyOut,
  output logic [NCH-1:0]   ovfFlag
);
  ctrlStrobe_t    strobe;
  logic [NCH-1:0] eligible;

  dreq_datapath #(.CNT_W(CNT_W), .BLK_W(BLK_W)) u_dp (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .chanInit(chanInit),
    .chanAuto(chanAuto), .blkLoad(blkLoad), .blkLen(blkLen),
    .strobe(strobe), .eligible(eligible), .ovfFlag(ovfFlag)
  );

  dreq_control u_ctl (
    .clk(clk), .rstN(rstN), .eligible(eligible), .flybyEn(flybyEn),
    .txnDone(txnDone), .strobe(strobe), .txnValid(txnValid),
    .txnChan(txnChan), .dataEn(dataEn), .flybyOut(flybyOut)
  );
endmodule

// File: rtl/dreq_checker.sv
module dreq_checker
  import dreq_pkg::*;
(
  input logic           clk,
  input logic           rstN,
  input logic           flybyEn,
  input logic           txnDone,
  input logic           txnValid,
  input logic [CHW-1:0] txnChan,
  input logic           dataEn,
  input logic           flybyOut,
  input logic [NCH-1:0] ovfFlag
);
  AST_FLYBY_CH0: assert property (@(posedge clk) disable iff (!rstN)
    flybyOut |-> (txnValid && txnChan == '0 && flybyEn)); // R7
  AST_FLYBY_NO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    flybyOut |-> !dataEn); // R7
  AST_TXN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txnValid && !txnDone) |=> (txnValid && $stable(txnChan))); // R5
  AST_TXN_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (txnValid && txnDone) |=> !txnValid); // R5

  for (genvar i = 0; i < NCH; i++) begin : g_ovf
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      ovfFlag[i] |=> ovfFlag[i]); // R4
  end
endmodule

bind dreq_arbiter dreq_checker u_chk (.*);

// File: tb/dreq_arbiter_tb.sv
module dreq_arbiter_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  reqIn, chanInit, chanAuto, blkLoad, ovfFlag;
  logic        flybyEn, txnDone, txnValid, dataEn, flybyOut;
  logic [15:0] blkLen;
  logic [1:0]  txnChan;

  int nChk = 0, nErr = 0;
  int got[4];
  int grantLog[64];
  int logN = 0;
  int flyErr = 0;
  int lat = 0;
  bit respEn = 1'b1;
  bit prevValid = 1'b0;
  int cyc = 0;

  always #4 clk = ~clk; // 125 MHz

  dreq_arbiter u_dut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .chanInit(chanInit),
    .chanAuto(chanAuto), .flybyEn(flybyEn), .blkLoad(blkLoad),
    .blkLen(blkLen), .txnDone(txnDone), .txnValid(txnValid),
    .txnChan(txnChan), .dataEn(dataEn), .flybyOut(flybyOut),
    .ovfFlag(ovfFlag)
  );

  task automatic chk(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int expCount(bit init, bit auto, int pulses);
    return (init && !auto) ? ((pulses > 15) ? 15 : pulses) : 0;
  endfunction

  // bus responder, grant log and flyby monitor
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (txnValid && !prevValid && logN < 64) begin
        grantLog[logN] = int'(txnChan);
        logN++;
      end
      prevValid = txnValid;
      if (txnValid) begin
        if (flybyOut != (flybyEn && txnChan == 2'd0) ||
            dataEn == (flybyEn && txnChan == 2'd0)) flyErr++;
      end
      if (txnDone) txnDone = 1'b0;
      else if (txnValid && respEn) begin
        if (lat == 0) begin
          txnDone = 1'b1;
          got[txnChan]++;
          lat = int'($urandom % 3);
        end else lat--;
      end
    end
  end

  task automatic clearCounts();
    foreach (got[i]) got[i] = 0;
    logN = 0;
  endtask

  task automatic pulse(logic [3:0] mask, int width);
    @(negedge clk) reqIn = mask;
    repeat (width - 1) @(negedge clk);
    @(negedge clk) reqIn = 4'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic drain();
    int idle = 0;
    while (idle < 30) begin
      @(negedge clk);
      if (txnValid) idle = 0; else idle++;
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    rstN = 1'b0; reqIn = '0; chanInit = '0; chanAuto = '0;
    flybyEn = 1'b0; blkLoad = '0; blkLen = '0; txnDone = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 txnValid", int'(txnValid), 0);
    chk("R10 dataEn", int'(dataEn), 0);
    chk("R10 flybyOut", int'(flybyOut), 0);
    chk("R10 ovfFlag", int'(ovfFlag), 0);

    // R1: one long pulse counts once
    chanInit = 4'b1000; clearCounts();
    pulse(4'b1000, 20);
    drain();
    chk("R1 long pulse", got[3], 1);

    // R2 R3 R7 R9: random traffic
    for (int ph = 0; ph < 8; ph++) begin
      int left[4];
      int sent[4];
      chanInit = 4'($urandom);
      chanAuto = (ph > 5) ? 4'($urandom) : 4'b0;
      flybyEn  = 1'($urandom);
      clearCounts();
      foreach (left[i]) begin left[i] = int'($urandom % 11); sent[i] = left[i]; end
      while (left[0] + left[1] + left[2] + left[3] > 0) begin
        logic [3:0] m;
        m = '0;
        for (int i = 0; i < 4; i++)
          if (left[i] > 0 && $urandom % 2 == 1) begin m[i] = 1'b1; left[i]--; end
        if (m != '0) pulse(m, 1 + int'($urandom % 4));
        repeat (int'($urandom % 3)) @(negedge clk);
      end
      drain();
      for (int i = 0; i < 4; i++)
        chk($sformatf("R2 R3 R9 phase %0d ch %0d", ph, i), got[i],
            expCount(chanInit[i], chanAuto[i], sent[i]));
    end
    chk("R7 flyby mismatches", flyErr, 0);
    chanAuto = '0;

    // R4: saturation with stalled bus
    chanInit = 4'b0010; respEn = 1'b0; clearCounts();
    for (int k = 0; k < 20; k++) pulse(4'b0010, 1);
    chk("R4 ovfFlag", int'(ovfFlag), 4'b0010);
    respEn = 1'b1;
    drain();
    chk("R4 saturated count", got[1], expCount(1'b1, 1'b0, 20));
    chk("R4 ovf sticky", int'(ovfFlag[1]), 1);

    // R3: clear init while pending, in-flight one still completes
    chanInit = 4'b0001; flybyEn = 1'b0; respEn = 1'b0; clearCounts();
    for (int k = 0; k < 4; k++) pulse(4'b0001, 2);
    @(negedge clk) chanInit = 4'b0000;
    @(negedge clk) chanInit = 4'b0001;
    respEn = 1'b1;
    drain();
    chk("R3 cleared pending", got[0], 1);

    // R6: rotating order
    chanInit = 4'b1111; respEn = 1'b0; clearCounts();
    for (int k = 0; k < 3; k++) pulse(4'b1111, 1);
    respEn = 1'b1;
    drain();
    chk("R6 grant count", logN, 12);
    for (int k = 1; k < 12; k++)
      chk($sformatf("R6 order step %0d", k), grantLog[k], (grantLog[k-1] + 1) % 4);

    // R8: autonomous block, edges ignored
    chanInit = 4'b0100; chanAuto = 4'b0100; clearCounts();
    blkLen = 16'd5;
    @(negedge clk) blkLoad = 4'b0100;
    @(negedge clk) blkLoad = 4'b0000;
    for (int k = 0; k < 3; k++) pulse(4'b0100, 1);
    drain();
    chk("R8 autonomous count", got[2], 5);
    chk("R3 auto edges ignored", got[0] + got[1] + got[3], 0);

    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    while (cyc < 150000) @(negedge clk);
    nChk++; nErr++;
    $display("FAIL watchdog act=%0d exp=0", cyc);
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule